// File: doc/BRIEF.md
# Three-Bank Ratio-Selectable Clock Divider

This block turns one fast clock into three banks of slower square waves. Each bank has its own select input that picks one of two fixed division ratios, and every output pin in a bank carries the same wave. A shared prescaler in front of all banks can halve the internal rate first. A bypass input swaps the source. In normal use the fast clock itself is the count source. In bypass, each rising edge of a slow reference input becomes one count step, so a designer can advance the whole tree one reference edge at a time.

All logic runs on the single fast clock and uses clock enables. A sampled reference edge or the prescaler phase produces a one-cycle "tick" that advances the bank counters. An active-high disable input holds every counter, the prescaler and the bank phases at zero. It also drops the per-bank output-enable flags, which stand in for high-impedance pads. Releasing the disable starts every bank on the same tick, so the banks stay edge-aligned. The select inputs and the prescaler select are captured only while the block is held.

Top module: `ckdiv_multibank`

## Requirements
- R1: Bank A drives NA identical outputs `qa`. Its period is 4 ticks when the captured `sel_a` is 0 and 6 ticks when it is 1.
- R2: Bank B drives NB identical outputs `qb`. Its period is 4 ticks when the captured `sel_b` is 0 and 2 ticks when it is 1.
- R3: Bank C drives NC identical outputs `qc`. Its period is 2 ticks when the captured `sel_c` is 0 and 4 ticks when it is 1.
- R4: With captured `range_sel` = 0, one tick occurs per source event. With `range_sel` = 1, one tick occurs per two source events, which doubles every bank period.
- R5: With `bypass_en` = 1, each source event is a rising edge of `ref_in`, seen through a two-flop synchronizer. The first such edge after release raises the bank outputs three clock edges after `ref_in` rises. While `ref_in` is idle, no output changes. With `bypass_en` = 0, every clock edge is a source event.
- R6: While `out_dis` is 1, from the next clock edge on, all of `oe_a`, `oe_b` and `oe_c` are 0 and all bank outputs are 0. One cycle after `out_dis` is low, all three enables are 1.
- R7: On the first tick after `out_dis` falls, all three banks rise together. When bypass is off, this tick is the first clock edge that samples `out_dis` low. After that, the rising edges of all banks coincide once every least common multiple of the bank periods.
- R8: A change on `sel_a`, `sel_b`, `sel_c` or `range_sel` while the block runs has no effect on any period. These inputs are captured only while `rst` or `out_dis` is high.
- R9: Synchronous `rst` acts like `out_dis`: from the next edge on, all outputs are 0 and all enables are 0.
- R10: Every bank output is a 50% duty-cycle wave. It is high for half its period in ticks and low for the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock, the oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Raw reference clock, sampled; the source in bypass |
| bypass_en | input | 1 | 1 selects reference-edge stepping |
| range_sel | input | 1 | 1 enables the shared divide-by-two prescaler |
| out_dis | input | 1 | 1 holds all counters and disables all outputs |
| sel_a | input | 1 | Bank A ratio select (0: /4, 1: /6) |
| sel_b | input | 1 | Bank B ratio select (0: /4, 1: /2) |
| sel_c | input | 1 | Bank C ratio select (0: /2, 1: /4) |
| qa | output | NA | Bank A outputs |
| qb | output | NB | Bank B outputs |
| qc | output | NC | Bank C outputs |
| oe_a | output | 1 | Bank A output enable (0 = high impedance) |
| oe_b | output | 1 | Bank B output enable |
| oe_c | output | 1 | Bank C output enable |

## Verification
The bench builds the block with its default parameters. These are fan-outs of 5, 4 and 2, half-period pairs (2,3), (2,1) and (1,2), and a two-flop reference synchronizer. The bench drives the reference with an 8-cycle period. With these values, bank periods from 2 to 32 clocks and alignment windows of 4, 12, 24 and 32 clocks fit inside a few hundred cycles. Each ratio pair, the prescaler and the bypass stepping can therefore be checked for exact periods, duty cycle, rise counts and coincident edges.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int max_half);
    return (max_half > 1) ? $clog2(max_half) : 1;
  endfunction

endpackage

// File: rtl/ckdiv_tick_src.sv
module ckdiv_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_in,
  input  logic bypass_en,
  input  logic range_sel,
  output logic tick
);

  logic [SYNC_STAGES:0] ref_sh;
  logic                 ref_edge;
  logic                 src_tick;
  logic                 range_l;
  logic                 pre_ph;

  // Reference synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) ref_sh <= '0;
    else     ref_sh <= {ref_sh[SYNC_STAGES-1:0], ref_in};
  end

  assign ref_edge = ref_sh[SYNC_STAGES-1] & ~ref_sh[SYNC_STAGES];
  assign src_tick = bypass_en ? ref_edge : 1'b1;

  // Prescaler: range select captured while held, phase cleared while held
  always_ff @(posedge clk) begin
    if (hold) begin
      range_l <= range_sel;
      pre_ph  <= 1'b0;
    end else if (src_tick) begin
      pre_ph  <= ~pre_ph;
    end
  end

  assign tick = src_tick & (range_l ? ~pre_ph : 1'b1);

endmodule

// File: rtl/ckdiv_bank.sv
module ckdiv_bank #(
  parameter int N_OUT = 1,
  parameter int HALF0 = 2,
  parameter int HALF1 = 3
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             tick,
  input  logic             sel,
  output logic [N_OUT-1:0] q
);

  localparam int HMAX = ckdiv_pkg::max2(HALF0, HALF1);
  localparam int CW   = ckdiv_pkg::cnt_width(HMAX);

  logic          sel_l;
  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;
  logic          ph;

  assign reload = sel_l ? CW'(HALF1 - 1) : CW'(HALF0 - 1);

  // Down counter: at zero it reloads and flips the phase, so the first
  // tick after release raises the output immediately.
  always_ff @(posedge clk) begin
    if (hold) begin
      sel_l <= sel;
      cnt   <= '0;
      ph    <= 1'b0;
    end else if (tick) begin
      if (cnt == '0) begin
        cnt <= reload;
        ph  <= ~ph;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_fan
    assign q[g] = ph;
  end

endmodule

// File: rtl/ckdiv_multibank.sv
module ckdiv_multibank #(
  parameter int NA          = 5,
  parameter int NB          = 4,
  parameter int NC          = 2,
  parameter int A_HALF0     = 2,
  parameter int A_HALF1     = 3,
  parameter int B_HALF0     = 2,
  parameter int B_HALF1     = 1,
  parameter int C_HALF0     = 1,
  parameter int C_HALF1     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          bypass_en,
  input  logic          range_sel,
  input  logic          out_dis,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          sel_c,
  output logic [NA-1:0] qa,
  output logic [NB-1:0] qb,
  output logic [NC-1:0] qc,
  output logic          oe_a,
  output logic          oe_b,
  output logic          oe_c
);

  logic hold;
  logic tick;
  logic [2:0] oe_r;

  assign hold = rst | out_dis;

  ckdiv_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .ref_in    (ref_in),
    .bypass_en (bypass_en),
    .range_sel (range_sel),
    .tick      (tick)
  );

  ckdiv_bank #(.N_OUT(NA), .HALF0(A_HALF0), .HALF1(A_HALF1)) u_bank_a (
    .clk(clk), .hold(hold), .tick(tick), .sel(sel_a), .q(qa)
  );

  ckdiv_bank #(.N_OUT(NB), .HALF0(B_HALF0), .HALF1(B_HALF1)) u_bank_b (
    .clk(clk), .hold(hold), .tick(tick), .sel(sel_b), .q(qb)
  );

  ckdiv_bank #(.N_OUT(NC), .HALF0(C_HALF0), .HALF1(C_HALF1)) u_bank_c (
    .clk(clk), .hold(hold), .tick(tick), .sel(sel_c), .q(qc)
  );

  always_ff @(posedge clk) begin
    if (hold) oe_r <= '0;
    else      oe_r <= '1;
  end

  assign oe_a = oe_r[0];
  assign oe_b = oe_r[1];
  assign oe_c = oe_r[2];

endmodule

// File: rtl/ckdiv_multibank_chk.sv
module ckdiv_multibank_chk #(
  parameter int NA = 5,
  parameter int NB = 4,
  parameter int NC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          out_dis,
  input logic          bypass_en,
  input logic          sel_c,
  input logic [NA-1:0] qa,
  input logic [NB-1:0] qb,
  input logic [NC-1:0] qc,
  input logic          oe_a,
  input logic          oe_b,
  input logic          oe_c
);

  logic pv = 1'b0;
  logic sel_c_cap = 1'b0;

  always_ff @(posedge clk) begin
    pv <= 1'b1;
    if (rst || out_dis) sel_c_cap <= sel_c;
  end

  // R6: disable quiets every output and enable from the next edge
  p_held_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    out_dis |=> (qa == '0 && qb == '0 && qc == '0 && !oe_a && !oe_b && !oe_c));

  // R6: one cycle after disable is low the enables are all on
  p_enabled_run_r6: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(out_dis) && !$past(rst)) |-> (oe_a && oe_b && oe_c));

  // R7: all banks rise together on the first edge after release
  p_release_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(out_dis) && !out_dis && !bypass_en) |=> (qa[0] && qb[0] && qc[0]));

  // R3: with bank C at its short ratio, every bank A rise is a bank C rise
  p_c_follows_a_r3: assert property (@(posedge clk) disable iff (rst)
    (pv && !sel_c_cap && $rose(qa[0])) |-> $rose(qc[0]));

endmodule

bind ckdiv_multibank ckdiv_multibank_chk #(.NA(NA), .NB(NB), .NC(NC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_dis   (out_dis),
  .bypass_en (bypass_en),
  .sel_c     (sel_c),
  .qa        (qa),
  .qb        (qb),
  .qc        (qc),
  .oe_a      (oe_a),
  .oe_b      (oe_b),
  .oe_c      (oe_c)
);

// File: tb/sim_ckdiv_multibank.sv
module sim_ckdiv_multibank;

  localparam int NA = 5;
  localparam int NB = 4;
  localparam int NC = 2;
  localparam int REFPER = 8;

  logic clk = 1'b0;
  logic rst, ref_in, bypass_en, range_sel, out_dis, sel_a, sel_b, sel_c;
  logic [NA-1:0] qa;
  logic [NB-1:0] qb;
  logic [NC-1:0] qc;
  logic oe_a, oe_b, oe_c;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ckdiv_multibank u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .bypass_en(bypass_en),
    .range_sel(range_sel), .out_dis(out_dis), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .qa(qa), .qb(qb), .qc(qc), .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gcd(input int a, input int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm(input int a, input int b);
    return a / gcd(a, b) * b;
  endfunction

  function automatic bit all_quiet();
    return (qa == '0 && qb == '0 && qc == '0 && !oe_a && !oe_b && !oe_c);
  endfunction

  task automatic hold_with(input logic sa, sb, sc, rng, byp);
    @(negedge clk);
    out_dis = 1'b1; sel_a = sa; sel_b = sb; sel_c = sc;
    range_sel = rng; bypass_en = byp; ref_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Periods, duty cycle, rise counts and alignment for one setting
  task automatic measure(input logic sa, sb, sc, rng, byp, input int ncyc,
                         input bit flip, input string tag);
    int per[3];
    int last[3];
    int nr[3];
    int ne[3];
    logic prv[3];
    logic cur[3];
    int off, al, lc, tk, nrise;
    string bank_req[3];
    bank_req[0] = "R1/R10"; bank_req[1] = "R2/R10"; bank_req[2] = "R3/R10";
    tk = byp ? REFPER : 1;
    per[0] = (sa ? 6 : 4) * (rng ? 2 : 1) * tk;
    per[1] = (sb ? 2 : 4) * (rng ? 2 : 1) * tk;
    per[2] = (sc ? 4 : 2) * (rng ? 2 : 1) * tk;
    off = byp ? 3 : 0;
    lc = lcm(lcm(per[0], per[1]), per[2]);
    hold_with(sa, sb, sc, rng, byp);
    chk(all_quiet(), "R6", {tag, " held outputs/enables"}, int'(qa), 0);
    for (int b = 0; b < 3; b++) begin
      last[b] = -1; nr[b] = 0; ne[b] = 0; prv[b] = 1'b0;
    end
    al = 0;
    out_dis = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (i == 0) chk(oe_a && oe_b && oe_c, "R6", {tag, " enables after release"},
                      int'({oe_a, oe_b, oe_c}), 7);
      cur[0] = qa[0]; cur[1] = qb[0]; cur[2] = qc[0];
      nrise = 0;
      for (int b = 0; b < 3; b++) begin
        if (cur[b] && !prv[b]) begin
          if (last[b] >= 0 && (i - last[b]) != per[b]) ne[b]++;
          if (last[b] < 0 && i != off) ne[b]++;
          last[b] = i;
          nr[b]++;
          nrise++;
        end
        if (!cur[b] && prv[b] && (i - last[b]) != per[b] / 2) ne[b]++;
        prv[b] = cur[b];
      end
      if (nrise == 3) al++;
      if (byp) ref_in = ((i % REFPER) < REFPER / 2);
      if (flip && i == ncyc / 2) begin
        sel_a = ~sa; sel_b = ~sb; sel_c = ~sc; range_sel = ~rng;
      end
    end
    for (int b = 0; b < 3; b++) begin
      chk(ne[b] == 0, {bank_req[b], " ", tag}, "edge timing errors", ne[b], 0);
      chk(nr[b] == (ncyc - 1 - off) / per[b] + 1, {bank_req[b], " ", tag}, "rise count",
          nr[b], (ncyc - 1 - off) / per[b] + 1);
    end
    chk(al == (ncyc - 1 - off) / lc + 1, {"R7 ", tag}, "coincident rises",
        al, (ncyc - 1 - off) / lc + 1);
  endtask

  task automatic test_reset_state();
    rst = 1'b1; out_dis = 1'b0; ref_in = 1'b0; bypass_en = 1'b0;
    range_sel = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
    repeat (4) @(negedge clk);
    chk(all_quiet(), "R9", "reset state", int'(qa), 0);
    rst = 1'b0;
  endtask

  task automatic test_bypass_step();
    hold_with(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    out_dis = 1'b0;
    repeat (20) @(negedge clk);
    chk(qa == '0 && qb == '0 && qc == '0, "R5", "idle reference, no toggle",
        int'(qc), 0);
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(qc[0] == 1'b1 && qa[0] == 1'b1, "R5", "first reference edge raises banks",
        int'(qc[0]), 1);
    ref_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(qc[0] == 1'b1, "R5", "no edge, no change", int'(qc[0]), 1);
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(qc[0] == 1'b0 && qa[0] == 1'b1, "R5", "second edge steps bank C only",
        int'({qa[0], qc[0]}), 2);
    ref_in = 1'b0;
  endtask

  task automatic test_disable_mid();
    hold_with(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    out_dis = 1'b0;
    repeat (7) @(negedge clk);
    out_dis = 1'b1;
    @(negedge clk);
    chk(all_quiet(), "R6", "disable mid-run", int'({oe_a, oe_b, oe_c}), 0);
    repeat (3) @(negedge clk);
    chk(all_quiet(), "R6", "disable held", int'(qa), 0);
  endtask

  task automatic test_reset_mid();
    hold_with(0, 1'b1, 0, 1'b1, 0);
    out_dis = 1'b0;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(all_quiet(), "R9", "reset mid-run", int'({oe_a, oe_b, oe_c}), 0);
    rst = 1'b0;
  endtask

  initial begin
    test_reset_state();
    measure(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 100, 1'b0, "low ratios");
    measure(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 100, 1'b0, "high ratios");
    measure(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 200, 1'b0, "R4 prescaler");
    measure(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 400, 1'b0, "R5 bypass");
    measure(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 120, 1'b1, "R8 select change ignored");
    test_bypass_step();
    test_disable_mid();
    test_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule